// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block is the controller-side state machine that takes a freshly powered SDRAM to its operational idle state. After reset it holds the command pins at NOP for a power-up interval. The length of that interval is computed at elaboration from a clock-period parameter and a delay parameter in nanoseconds. It then precharges every bank, issues exactly two auto-refresh commands and loads the mode register. Each command is followed by a timed gap whose length in clock cycles is a parameter.

The mode word is assembled from four configuration inputs: burst length code, burst ordering, CAS latency and write-burst behaviour. The operating-mode and reserved bits are forced to zero. When the last gap has run out, the block raises `init_done` and keeps driving NOP with a zero address. Neighbouring logic uses this flag to take over the command bus. The flag stays high until the next reset.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset (`rst_n` low, synchronous) is applied, and on the first cycle after it is released, the pins carry NOP, the address and bank address are zero, and `init_done` is low. Command codes on {cs_n, ras_n, cas_n, we_n} are NOP 0111, PRECHARGE 0010, AUTO REFRESH 0001 and LOAD MODE 0000.
- R2: Cycles 0 to P-1 after reset release carry NOP with a zero address. Cycle 0 is the first cycle with `rst_n` high, and P = ceil(POWERUP_NS*1000 / CLK_PERIOD_PS).
- R3: PRECHARGE is issued in cycle P with address bit 10 high, all other address bits zero and bank address 00.
- R4: Exactly two AUTO REFRESH commands are issued, in cycles P+T_RP and P+T_RP+T_RFC, each with a zero address.
- R5: LOAD MODE is issued once, in cycle P+T_RP+2*T_RFC, with bank address 00.
- R6: During LOAD MODE the address carries the mode word. Bits 2:0 hold the burst length code, bit 3 the burst ordering, bits 6:4 the CAS latency, bits 8:7 are 00, bit 9 holds the write-burst select and bits 11:10 are 00.
- R7: Every cycle other than those four commands carries NOP with a zero address. No two commands are issued in adjacent cycles (each gap parameter is at least 2).
- R8: `init_done` is low until cycle P+T_RP+2*T_RFC+T_MRD and high from then on, with NOP on the pins, until reset.
- R9: A reset applied part-way through the sequence restarts it from the power-up wait, with the same cycle timing as after the first reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code placed in mode bits 2:0 |
| cfg_burst_interleave | input | 1 | Burst ordering placed in mode bit 3 |
| cfg_cas_lat | input | 3 | CAS latency code placed in mode bits 6:4 |
| cfg_write_single | input | 1 | Write-burst select placed in mode bit 9 |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | ADDR_W | Address bus (12 bits by default) |
| sd_ba | output | BA_W | Bank address (2 bits by default) |
| init_done | output | 1 | High once the sequence has completed |

## Verification
The bench sweeps every combination of the four mode inputs and compares every pin in every cycle against a schedule worked out by arithmetic. An off-by-one in any gap counter therefore shows up as a command one cycle early or late. A wrong rounding of the power-up count moves the precharge, because the bench uses a delay that is not a whole number of clock periods. A mode word with fields swapped or shifted fails on at least one of the swept values, and reserved bits left unforced show up as nonzero address bits. A design whose done flag rises at the load-mode cycle or one cycle late fails the done comparison. A design that does not fully restart after a mid-sequence reset issues its next command at the wrong cycle of the restarted run.

// File: rtl/sdram_init_pkg.sv
`timescale 1ns/1ps
// sdram_init_pkg: shared command codes, FSM states and the mode-word packer
// for the SDRAM power-up sequencer.
// Assumes command bit order {cs_n, ras_n, cas_n, we_n}.
package sdram_init_pkg;

    localparam int MODE_W = 12;

    typedef enum logic [3:0] {
        CMD_LMR = 4'b0000,
        CMD_REF = 4'b0001,
        CMD_PRE = 4'b0010,
        CMD_NOP = 4'b0111
    } sd_cmd_e;

    typedef enum logic [3:0] {
        ST_PWR,
        ST_PRE,
        ST_TRP,
        ST_REF1,
        ST_TRFC1,
        ST_REF2,
        ST_TRFC2,
        ST_LMR,
        ST_TMRD,
        ST_DONE
    } init_st_e;

    // Build the 12-bit mode word; operating mode and reserved bits are zero.
    function automatic logic [MODE_W-1:0] pack_mode(
        input logic [2:0] burst_len,
        input logic       burst_ilv,
        input logic [2:0] cas_lat,
        input logic       wr_single
    );
        return {2'b00, wr_single, 2'b00, cas_lat, burst_ilv, burst_len};
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
`timescale 1ns/1ps
// sdram_init_timer: down-counter shared by the power-up wait and the
// inter-command gaps.
// It resets to INIT_VAL, reloads on 'load', and otherwise counts down to zero
// and holds there. 'last' is high when the count is 1, so the state machine can
// step on that edge and the next command lands exactly on the gap boundary.
// Assumes every loaded value and INIT_VAL are at least 1.
module sdram_init_timer #(
    parameter int CNT_W    = 8,
    parameter int INIT_VAL = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             last
);

    logic [CNT_W-1:0] cnt_q;

    // Counter register: reset value, reload, or saturating decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_W'(INIT_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // Final-cycle flag for the controlling state machine.
    assign last = (cnt_q == CNT_W'(1));

    // A reload value of zero would stall the sequence (R7 gap rule).
    assert_load_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/sdram_init_modeword.sv
`timescale 1ns/1ps
// sdram_init_modeword: assembles the mode-register word from the
// configuration inputs.
// Assumes the inputs are held stable for the whole sequence.
module sdram_init_modeword
    import sdram_init_pkg::*;
(
    input  logic [2:0]        burst_len,
    input  logic              burst_ilv,
    input  logic [2:0]        cas_lat,
    input  logic              wr_single,
    output logic [MODE_W-1:0] mode_word
);

    // Pure field placement, no state.
    always_comb begin
        mode_word = pack_mode(burst_len, burst_ilv, cas_lat, wr_single);
    end

endmodule

// File: rtl/sdram_init_pins.sv
`timescale 1ns/1ps
// sdram_init_pins: turns the current command into SDRAM pin levels.
// PRECHARGE sets address bit 10 (all banks), LOAD MODE puts the mode word on
// the address, and every other command drives a zero address. The bank address
// is always zero.
// Assumes ADDR_W >= MODE_W.
module sdram_init_pins
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int BA_W   = 2
) (
    input  sd_cmd_e           cmd,
    input  logic [MODE_W-1:0] mode_word,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] addr,
    output logic [BA_W-1:0]   ba
);

    localparam int ALL_BANK_BIT = 10;

    // Split the command code onto the four strobes.
    assign {cs_n, ras_n, cas_n, we_n} = cmd;

    // Select what the address bus carries for this command.
    always_comb begin
        addr = '0;
        ba   = '0;
        case (cmd)
            CMD_PRE: addr[ALL_BANK_BIT] = 1'b1;
            CMD_LMR: addr = ADDR_W'(mode_word);
            default: addr = '0;
        endcase
    end

endmodule

// File: rtl/sdram_init_seq.sv
`timescale 1ns/1ps
// sdram_init_seq: top of the SDRAM power-up sequencer.
// Runs NOP wait -> precharge all -> refresh -> refresh -> load mode -> done,
// with a timed gap after every command. The wait length comes from
// CLK_PERIOD_PS and POWERUP_NS. The gaps T_RP, T_RFC and T_MRD are in clock
// cycles and must each be at least 2. Outputs are decoded from registered state.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int POWERUP_NS    = 100000,
    parameter int T_RP          = 3,
    parameter int T_RFC         = 14,
    parameter int T_MRD         = 2,
    parameter int ADDR_W        = 12,
    parameter int BA_W          = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        cfg_burst_len,
    input  logic              cfg_burst_interleave,
    input  logic [2:0]        cfg_cas_lat,
    input  logic              cfg_write_single,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [ADDR_W-1:0] sd_addr,
    output logic [BA_W-1:0]   sd_ba,
    output logic              init_done
);

    localparam longint PWR_PS  = longint'(POWERUP_NS) * 1000;
    localparam int     PWR_CYC = int'((PWR_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS);
    localparam int     GAP_MAX = (T_RFC > T_RP) ? ((T_RFC > T_MRD) ? T_RFC : T_MRD)
                                                : ((T_RP > T_MRD) ? T_RP : T_MRD);
    localparam int     CNT_MAX = (PWR_CYC > GAP_MAX) ? PWR_CYC : GAP_MAX;
    localparam int     CNT_W   = $clog2(CNT_MAX + 1);

    init_st_e          st_q, st_d;
    sd_cmd_e           cmd;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_last;
    logic [MODE_W-1:0] mode_word;

    // State register; reset restarts at the power-up wait.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_PWR;
        else        st_q <= st_d;
    end

    // Sequence order: command states last one cycle, gap states wait for the timer.
    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_PWR:   if (tmr_last) st_d = ST_PRE;
            ST_PRE:   st_d = ST_TRP;
            ST_TRP:   if (tmr_last) st_d = ST_REF1;
            ST_REF1:  st_d = ST_TRFC1;
            ST_TRFC1: if (tmr_last) st_d = ST_REF2;
            ST_REF2:  st_d = ST_TRFC2;
            ST_TRFC2: if (tmr_last) st_d = ST_LMR;
            ST_LMR:   st_d = ST_TMRD;
            ST_TMRD:  if (tmr_last) st_d = ST_DONE;
            default:  st_d = ST_DONE;
        endcase
    end

    // Gap length loaded on the cycle each command is on the pins.
    always_comb begin
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (st_q)
            ST_PRE:           begin tmr_load = 1'b1; tmr_val = CNT_W'(T_RP - 1);  end
            ST_REF1, ST_REF2: begin tmr_load = 1'b1; tmr_val = CNT_W'(T_RFC - 1); end
            ST_LMR:           begin tmr_load = 1'b1; tmr_val = CNT_W'(T_MRD - 1); end
            default:          begin tmr_load = 1'b0; tmr_val = '0;                end
        endcase
    end

    // Command decode from state.
    always_comb begin
        case (st_q)
            ST_PRE:           cmd = CMD_PRE;
            ST_REF1, ST_REF2: cmd = CMD_REF;
            ST_LMR:           cmd = CMD_LMR;
            default:          cmd = CMD_NOP;
        endcase
    end

    assign init_done = (st_q == ST_DONE);

    sdram_init_timer #(
        .CNT_W    (CNT_W),
        .INIT_VAL (PWR_CYC)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .last     (tmr_last)
    );

    sdram_init_modeword u_mode (
        .burst_len (cfg_burst_len),
        .burst_ilv (cfg_burst_interleave),
        .cas_lat   (cfg_cas_lat),
        .wr_single (cfg_write_single),
        .mode_word (mode_word)
    );

    sdram_init_pins #(
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W)
    ) u_pins (
        .cmd       (cmd),
        .mode_word (mode_word),
        .cs_n      (sd_cs_n),
        .ras_n     (sd_ras_n),
        .cas_n     (sd_cas_n),
        .we_n      (sd_we_n),
        .addr      (sd_addr),
        .ba        (sd_ba)
    );

    // Assertion support: number of refresh commands seen on the pins since reset.
    logic [3:0] pin_cmd;
    logic [1:0] ref_seen_q;
    assign pin_cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

    always_ff @(posedge clk) begin
        if (!rst_n)                                      ref_seen_q <= '0;
        else if (pin_cmd == 4'b0001 && ref_seen_q != 2'd3) ref_seen_q <= ref_seen_q + 1'b1;
    end

    assert_pre_all_banks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0010) |-> (sd_addr[10] && sd_ba == '0));

    assert_two_refresh_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0001) |-> (ref_seen_q < 2'd2));

    assert_lmr_after_refresh_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0000) |-> (ref_seen_q == 2'd2 && sd_ba == '0));

    assert_mode_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd == 4'b0000) |-> (sd_addr[11:10] == 2'b00 && sd_addr[8:7] == 2'b00));

    assert_nop_after_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_cmd != 4'b0111) |=> (pin_cmd == 4'b0111));

    assert_done_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    assert_done_bus_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (pin_cmd == 4'b0111 && sd_addr == '0));

endmodule

// File: tb/tb_sdram_init_seq.sv
`timescale 1ns/1ps
// tb_sdram_init_seq: sweeps all mode-input combinations and compares every pin
// in every cycle against an arithmetic schedule.
module tb_sdram_init_seq;

    localparam int CLK_PS = 5000;
    localparam int PWR_NS = 203;   // not a whole number of periods: tests rounding up
    localparam int TRP    = 3;
    localparam int TRFC   = 7;
    localparam int TMRD   = 2;
    localparam int P      = (PWR_NS * 1000 + CLK_PS - 1) / CLK_PS;   // 41
    localparam int C_REF1 = P + TRP;
    localparam int C_REF2 = C_REF1 + TRFC;
    localparam int C_LMR  = C_REF2 + TRFC;
    localparam int C_DONE = C_LMR + TMRD;
    localparam int RUN_LEN = C_DONE + 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_bl = '0;
    logic        cfg_bt = 1'b0;
    logic [2:0]  cfg_cl = '0;
    logic        cfg_wb = 1'b0;
    logic        cs_n, ras_n, cas_n, we_n, done;
    logic [11:0] addr;
    logic [1:0]  ba;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    sdram_init_seq #(
        .CLK_PERIOD_PS (CLK_PS),
        .POWERUP_NS    (PWR_NS),
        .T_RP          (TRP),
        .T_RFC         (TRFC),
        .T_MRD         (TMRD),
        .ADDR_W        (12),
        .BA_W          (2)
    ) dut (
        .clk                  (clk),
        .rst_n                (rst_n),
        .cfg_burst_len        (cfg_bl),
        .cfg_burst_interleave (cfg_bt),
        .cfg_cas_lat          (cfg_cl),
        .cfg_write_single     (cfg_wb),
        .sd_cs_n              (cs_n),
        .sd_ras_n             (ras_n),
        .sd_cas_n             (cas_n),
        .sd_we_n              (we_n),
        .sd_addr              (addr),
        .sd_ba                (ba),
        .init_done            (done)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // One full (or truncated) sequence; 'restart' tags the wait-phase checks R9.
    task automatic run(input logic [2:0] bl, input logic bt, input logic [2:0] cl,
                       input logic wb, input int ncyc, input bit restart);
        logic [11:0] mode_exp;
        cfg_bl = bl; cfg_bt = bt; cfg_cl = cl; cfg_wb = wb;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "cmd_in_reset", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk("R1", "addr_in_reset", addr, 0);
        chk("R1", "done_in_reset", done, 0);
        rst_n = 1'b1;
        mode_exp = {2'b00, wb, 2'b00, cl, bt, bl};
        for (int k = 0; k < ncyc; k++) begin
            string tag;
            int    ecmd;
            int    eaddr;
            if (k == 0)                       tag = "R1";
            else if (k < P)                   tag = restart ? "R9" : "R2";
            else if (k == P)                  tag = "R3";
            else if (k == C_REF1 || k == C_REF2) tag = "R4";
            else if (k == C_LMR)              tag = "R5";
            else if (k >= C_DONE)             tag = "R8";
            else                              tag = "R7";
            ecmd = 4'b0111; eaddr = 0;
            if (k == P)                            begin ecmd = 4'b0010; eaddr = 12'h400; end
            else if (k == C_REF1 || k == C_REF2)   begin ecmd = 4'b0001; eaddr = 0; end
            else if (k == C_LMR)                   begin ecmd = 4'b0000; eaddr = int'(mode_exp); end
            chk(tag, "cmd", {cs_n, ras_n, cas_n, we_n}, ecmd);
            chk((k == C_LMR) ? "R6" : tag, "addr", addr, eaddr);
            chk(tag, "ba", ba, 0);
            chk((k >= C_LMR - 1) ? "R8" : tag, "done", done, (k >= C_DONE) ? 1 : 0);
            @(negedge clk);
        end
    endtask

    initial begin
        // Truncated run, then a reset mid-sequence: the next run must restart (R9).
        run(3'd2, 1'b0, 3'd2, 1'b0, C_REF1 + 4, 1'b0);
        run(3'd2, 1'b0, 3'd2, 1'b0, RUN_LEN, 1'b1);
        // Exhaustive sweep of the mode inputs (R6 and the whole schedule).
        for (int i = 0; i < 256; i++) begin
            run(3'(i), 1'(i >> 3), 3'(i >> 4), 1'(i >> 7), RUN_LEN, 1'b0);
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired before the bench finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule